// File: doc/BRIEF.md
# Dadda-Tree Unsigned Multiplier

A purely combinational unsigned multiplier. Every operand bit pair is ANDed into a partial-product array, so that column `c` holds all bits `a[i] & b[k]` with `i + k = c`. A sequence of column-compression stages then lowers the heights. Each stage has a height limit. Within a stage the columns are visited from weight 0 upward. The carries that a column receives from the column below are counted in its height. Only as many 3:2 and 2:2 counters are placed as are needed to bring that column down to the limit, and no more. Once the limit-2 stage has run, two rows are left. A ripple carry-propagate adder sums them into the `N1 + N2`-bit product.

The stage limits follow the sequence 2, 3, 4, 6, 9, 13, ... (each term is the floor of 1.5 times the one before). The first stage uses the largest term that is strictly below the shorter operand width. This is the tallest column of the array. All counter counts and all wiring are worked out at elaboration time from the operand-width parameters, so any pair of widths up to 64 product bits builds the correct tree. The default is 8 by 8, which gives four stages with limits 6, 4, 3 and 2.

Top module: `dadda_mul`

## Requirements
- R1: For all operands, `prod` equals the unsigned product `op_a * op_b` as an `N1 + N2`-bit value, with no clock or latency.
- R2: When either operand is zero, `prod` is zero.
- R3: `prod[0]` equals `op_a[0] & op_b[0]`. Column 0 holds a single bit and no counter acts on it.
- R4: All-ones operands give `(2^N1 - 1) * (2^N2 - 1)`. This is 16'hFE01 for 8 by 8.
- R5: The stage limit of stage index `s` (0 first) is term `S - s` of the sequence `d1 = 2`, `d(j+1) = floor(1.5 * dj)`. `S` is the largest `j` with `dj < min(N1, N2)`. For 8 by 8 this gives `S = 4` and limits 6, 4, 3, 2.
- R6: After the last stage, every column holds at most two live bits. All higher slots are zero.
- R7: The final carry-propagate adder never produces a carry out of the top product bit.
- R8: Multiplying by a power of two `2^k` returns the other operand shifted left by `k`. Multiplying by one returns the other operand unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N1 | Unsigned multiplicand |
| op_b | input | N2 | Unsigned multiplier |
| prod | output | N1+N2 | Unsigned product |

## Verification
All 65536 operand pairs of the 8 by 8 case are applied and compared with a behavioural multiply. Any wrongly placed counter, dropped carry or misrouted slot in any stage therefore shows up as a wrong product. Before that sweep, directed patterns are tried. Zero operands show that no stray bit reaches the adder. All-ones operands make every column as tall as it can be and push carries through the whole adder chain. Power-of-two and unit multipliers pass a single partial-product row through every stage untouched, which separates routing faults from adder faults. The stage-limit function is checked against the expected 6, 4, 3, 2 schedule.

// File: rtl/dadda_pkg.sv
package dadda_pkg;

    // Largest product width the elaboration-time planner supports
    localparam int MAXC = 64;

    // Output of a 3:2 or 2:2 counter
    typedef struct packed {
        logic carry;
        logic sum;
    } sc_t;

    // Selectors for plan_q
    typedef enum int {
        Q_HEIGHT = 0,
        Q_FULL   = 1,
        Q_HALF   = 2,
        Q_CIN    = 3
    } plan_sel_e;

    function automatic int min_w(input int n1, input int n2);
        return (n1 < n2) ? n1 : n2;
    endfunction

    // Term j (j >= 1) of the height-limit sequence
    function automatic int d_term(input int j);
        int d;
        d = 2;
        for (int i = 1; i < j; i++) d = (d * 3) / 2;
        return d;
    endfunction

    // Number of compression stages for given operand widths
    function automatic int stage_count(input int n1, input int n2);
        int j;
        j = 0;
        while (d_term(j + 1) < min_w(n1, n2)) j++;
        return j;
    endfunction

    // Height limit of stage index s (0 is the first stage)
    function automatic int stage_limit(input int n1, input int n2, input int s);
        return d_term(stage_count(n1, n2) - s);
    endfunction

    // Number of partial products in column c
    function automatic int init_height(input int n1, input int n2, input int c);
        int lo;
        int hi;
        lo = (c - n2 + 1 > 0) ? (c - n2 + 1) : 0;
        hi = (c < n1 - 1) ? c : (n1 - 1);
        return (hi >= lo) ? (hi - lo + 1) : 0;
    endfunction

    // Walk the reduction up to stage s, column c and report one quantity
    function automatic int plan_q(input int n1, input int n2, input int s,
                                  input int c, input plan_sel_e sel);
        int h   [MAXC];
        int nxt [MAXC];
        int cin;
        int tot;
        int ex;
        int nf;
        int nh;
        int lim;
        for (int k = 0; k < MAXC; k++) begin
            h[k]   = init_height(n1, n2, k);
            nxt[k] = 0;
        end
        for (int st = 0; st <= s; st++) begin
            lim = stage_limit(n1, n2, st);
            cin = 0;
            for (int k = 0; k < n1 + n2; k++) begin
                tot = h[k] + cin;
                ex  = (tot > lim) ? (tot - lim) : 0;
                nf  = ex / 2;
                nh  = ex % 2;
                if (st == s && k == c) begin
                    case (sel)
                        Q_HEIGHT: return h[k];
                        Q_FULL:   return nf;
                        Q_HALF:   return nh;
                        default:  return cin;
                    endcase
                end
                nxt[k] = tot - 2 * nf - nh;
                cin    = nf + nh;
            end
            for (int k = 0; k < MAXC; k++) h[k] = nxt[k];
        end
        return 0;
    endfunction

endpackage

// File: rtl/csa_cell.sv
module csa_cell (
    input  logic          x,
    input  logic          y,
    input  logic          z,
    output dadda_pkg::sc_t o
);
    assign o.sum   = x ^ y ^ z;
    assign o.carry = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/hsa_cell.sv
module hsa_cell (
    input  logic          x,
    input  logic          y,
    output dadda_pkg::sc_t o
);
    assign o.sum   = x ^ y;
    assign o.carry = x & y;
endmodule

// File: rtl/dadda_ppgen.sv
module dadda_ppgen #(
    parameter int N1 = 8,
    parameter int N2 = 8,
    localparam int W = N1 + N2,
    localparam int H = dadda_pkg::min_w(N1, N2)
) (
    input  logic [N1-1:0]         a,
    input  logic [N2-1:0]         b,
    output logic [W-1:0][H-1:0]   cols
);
    for (genvar c = 0; c < W; c++) begin : g_col
        localparam int LO = (c - N2 + 1 > 0) ? (c - N2 + 1) : 0;
        localparam int HT = dadda_pkg::init_height(N1, N2, c);
        for (genvar k = 0; k < H; k++) begin : g_slot
            if (k < HT) begin : g_live
                assign cols[c][k] = a[LO + k] & b[c - LO - k];
            end else begin : g_zero
                assign cols[c][k] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/dadda_stage.sv
module dadda_stage #(
    parameter int N1  = 8,
    parameter int N2  = 8,
    parameter int STG = 0,
    localparam int W   = N1 + N2,
    localparam int H   = dadda_pkg::min_w(N1, N2),
    localparam int LIM = dadda_pkg::stage_limit(N1, N2, STG)
) (
    input  logic [W-1:0][H-1:0] bits_in,
    output logic [W-1:0][H-1:0] bits_out
);
    import dadda_pkg::*;

    // Carries leaving each column towards the next one up
    logic [W-1:0][H-1:0] cy;

    for (genvar c = 0; c < W; c++) begin : g_col
        localparam int HI   = plan_q(N1, N2, STG, c, Q_HEIGHT);
        localparam int NF   = plan_q(N1, N2, STG, c, Q_FULL);
        localparam int NH   = plan_q(N1, N2, STG, c, Q_HALF);
        localparam int CI   = plan_q(N1, N2, STG, c, Q_CIN);
        localparam int CO   = NF + NH;
        localparam int USED = 3 * NF + 2 * NH;
        localparam int PASS = HI - USED;
        localparam int NOUT = CO + PASS + CI;

        for (genvar f = 0; f < NF; f++) begin : g_fa
            sc_t r;
            csa_cell u_fa (
                .x(bits_in[c][3*f]),
                .y(bits_in[c][3*f+1]),
                .z(bits_in[c][3*f+2]),
                .o(r)
            );
            assign bits_out[c][f] = r.sum;
            assign cy[c][f]       = r.carry;
        end

        if (NH > 0) begin : g_ha
            sc_t r;
            hsa_cell u_ha (
                .x(bits_in[c][3*NF]),
                .y(bits_in[c][3*NF+1]),
                .o(r)
            );
            assign bits_out[c][NF] = r.sum;
            assign cy[c][NF]       = r.carry;
        end

        for (genvar p = 0; p < PASS; p++) begin : g_pass
            assign bits_out[c][CO + p] = bits_in[c][USED + p];
        end

        if (c > 0) begin : g_cin
            for (genvar k = 0; k < CI; k++) begin : g_k
                assign bits_out[c][CO + PASS + k] = cy[c-1][k];
            end
        end

        for (genvar z = NOUT; z < H; z++) begin : g_ozero
            assign bits_out[c][z] = 1'b0;
        end
        for (genvar z = CO; z < H; z++) begin : g_czero
            assign cy[c][z] = 1'b0;
        end

        if (HI < H) begin : g_inchk
            always_comb begin
                // R6
                empty_slots_in_chk: assert (bits_in[c][H-1:HI] == '0)
                    else $error("stage %0d col %0d: slot above height is live", STG, c);
            end
        end

        if (NOUT > LIM) begin : g_bad
            // The planner must never leave a column above the stage limit
            always_comb begin
                // R5
                stage_height_chk: assert (1'b0 == |bits_out[c])
                    else $error("stage %0d col %0d exceeds limit %0d", STG, c, LIM);
            end
        end
    end

    always_comb begin
        // R7
        top_col_carry_chk: assert (cy[W-1] == '0)
            else $error("stage %0d: carry leaves top column", STG);
    end
endmodule

// File: rtl/dadda_cpa.sv
module dadda_cpa #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);
    import dadda_pkg::*;

    logic [W:0] c;
    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        sc_t r;
        csa_cell u_fa (
            .x(x[i]),
            .y(y[i]),
            .z(c[i]),
            .o(r)
        );
        assign s[i]   = r.sum;
        assign c[i+1] = r.carry;
    end

    always_comb begin
        // R7
        no_overflow_chk: assert (c[W] == 1'b0)
            else $error("final adder carried out of product width");
    end
endmodule

// File: rtl/dadda_mul.sv
module dadda_mul #(
    parameter int N1 = 8,
    parameter int N2 = 8,
    localparam int W = N1 + N2,
    localparam int H = dadda_pkg::min_w(N1, N2),
    localparam int S = dadda_pkg::stage_count(N1, N2)
) (
    input  logic [N1-1:0] op_a,
    input  logic [N2-1:0] op_b,
    output logic [W-1:0]  prod
);
    logic [W-1:0][H-1:0] lvl [0:S];
    logic [W-1:0]        row_a;
    logic [W-1:0]        row_b;

    dadda_ppgen #(.N1(N1), .N2(N2)) u_pp (
        .a   (op_a),
        .b   (op_b),
        .cols(lvl[0])
    );

    for (genvar s = 0; s < S; s++) begin : g_stage
        dadda_stage #(.N1(N1), .N2(N2), .STG(s)) u_stg (
            .bits_in (lvl[s]),
            .bits_out(lvl[s+1])
        );
    end

    for (genvar c = 0; c < W; c++) begin : g_rows
        assign row_a[c] = lvl[S][c][0];
        if (H >= 2) begin : g_two
            assign row_b[c] = lvl[S][c][1];
        end else begin : g_one
            assign row_b[c] = 1'b0;
        end
        if (H > 2) begin : g_chk
            always_comb begin
                // R6
                final_two_rows_chk: assert (lvl[S][c][H-1:2] == '0)
                    else $error("column %0d taller than two after last stage", c);
            end
        end
    end

    dadda_cpa #(.W(W)) u_cpa (
        .x(row_a),
        .y(row_b),
        .s(prod)
    );

    always_comb begin
        // R2
        zero_operand_chk: assert (!((op_a == '0) || (op_b == '0)) || (prod == '0))
            else $error("nonzero product from a zero operand");
        // R3
        lsb_product_chk: assert (prod[0] == (op_a[0] & op_b[0]))
            else $error("product bit 0 mismatch");
    end
endmodule

// File: tb/dadda_mul_tb.sv
module dadda_mul_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N1 = 8;
    localparam int N2 = 8;
    localparam int W  = N1 + N2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N1-1:0] op_a = '0;
    logic [N2-1:0] op_b = '0;
    logic [W-1:0]  prod;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // Reference model: expected products and their tags, in issue order
    int unsigned exp_q [$];
    string       tag_q [$];

    dadda_mul #(.N1(N1), .N2(N2)) u_dut (
        .op_a(op_a),
        .op_b(op_b),
        .prod(prod)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int unsigned got, input int unsigned exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h (a=%0h b=%0h)", tag, got, exp, op_a, op_b);
        end
    endtask

    // Drive one pair just after a rising edge; compare at the following falling edge
    task automatic apply(input int unsigned a, input int unsigned b, input string tag);
        @(posedge clk);
        #1;
        op_a = a[N1-1:0];
        op_b = b[N2-1:0];
        exp_q.push_back((a * b) & ((1 << W) - 1));
        tag_q.push_back(tag);
        @(negedge clk);
        check(tag_q.pop_front(), prod, exp_q.pop_front());
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // Reset state: operands held at zero, product must be zero (R2)
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 reset", prod, 0);
        rst = 1'b0;

        // R5: stage schedule for 8 by 8
        check("R5 count", dadda_pkg::stage_count(N1, N2), 4);
        check("R5 lim0", dadda_pkg::stage_limit(N1, N2, 0), 6);
        check("R5 lim1", dadda_pkg::stage_limit(N1, N2, 1), 4);
        check("R5 lim2", dadda_pkg::stage_limit(N1, N2, 2), 3);
        check("R5 lim3", dadda_pkg::stage_limit(N1, N2, 3), 2);
        check("R5 d5", dadda_pkg::d_term(5), 9);

        // R2: zero operands
        apply(0, 8'hFF, "R2 a zero");
        apply(8'hA5, 0, "R2 b zero");
        apply(0, 0, "R2 both zero");

        // R3: low bit
        apply(1, 1, "R3 lsb one");
        apply(8'hFE, 8'hFF, "R3 lsb even");
        @(negedge clk);
        check("R3 bit0", {31'd0, prod[0]}, 0);

        // R4: all ones, longest carry chain
        apply(8'hFF, 8'hFF, "R4 max");
        @(negedge clk);
        check("R4 value", prod, 16'hFE01);

        // R8: unit and power-of-two multipliers
        apply(8'hC3, 1, "R8 unit b");
        apply(1, 8'h5A, "R8 unit a");
        for (int k = 0; k < N2; k++) apply(8'hB7, 1 << k, "R8 shift b");
        for (int k = 0; k < N1; k++) apply(1 << k, 8'h6D, "R8 shift a");

        // R1, R6, R7: exhaustive sweep
        for (int a = 0; a < (1 << N1); a++)
            for (int b = 0; b < (1 << N2); b++)
                apply(a, b, "R1 sweep");

        finish_run();
    end
endmodule